// File: doc/BRIEF.md
# Multi-Register String Transfer Sequencer

This block moves a run of bytes between a 32-entry, 32-bit register file and a byte-addressable memory port, one memory beat per cycle. A single start pulse supplies a base address, a byte count, the first register index and a load/store select. Full words go on each beat while four or more bytes remain. A short tail of one to three bytes is carried in the upper lanes of the next register. The register index wraps from 31 back to 0.

For loads, an optional legality check looks at two protected register indices: a base index and an offset index. If either of them lies in the range of registers the load would write, the load is refused. The block then raises a flag and touches nothing. The register file is external: the block drives a read index and reads the data back in the same cycle, and it drives a write strobe, index and data. Memory answers through a ready signal, and load data is valid in the cycle that ready is high.

Top module: `string_xfer_seq`

## Requirements
- R1: A start with a byte count of zero finishes with a done pulse and issues no memory request and no register write.
- R2: While four or more bytes remain, each beat is a word access (`mem_size` = 2; 1 = halfword, 0 = byte). The word is big-endian: the register's bit 31..24 lane is at the lowest address. After the beat the address steps by 4 and the register index by 1. Data on the memory port is right-justified.
- R3: The register index counts modulo 32, so a transfer that runs past register 31 continues at register 0.
- R4: On a load, a tail of 1, 2 or 3 bytes lands in the top byte lanes of the next register. The lower lanes of that register are written as zero.
- R5: On a store, a tail of 1, 2 or 3 bytes writes only the top 1, 2 or 3 bytes of the next register to memory, most significant byte at the lowest address.
- R6: A 3-byte tail is done as a halfword access at the current address, then a byte access at that address plus 2.
- R7: With the check enabled on a nonzero-count load, the number of registers touched is the byte count divided by 4, rounded up, counted from the first index with wrap. If the base index (only when it is nonzero) or the offset index falls in that range, `illegal` is raised together with `done`, and no memory or register access happens.
- R8: Address increments wrap modulo 2^32.
- R9: `done` is high for exactly one cycle after the last beat completes. A start that arrives while the block is busy is ignored.
- R10: A memory request that is not accepted keeps its address and size unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| st_addr | input | 32 | Base byte address |
| st_count | input | 7 | Byte count |
| st_reg | input | 5 | First register index |
| st_store | input | 1 | 1 = store (registers to memory), 0 = load |
| st_check | input | 1 | Enable the protected-register check (loads only) |
| st_base | input | 5 | Protected base index (0 means none) |
| st_index | input | 5 | Protected offset index |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 32 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store beat) |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Store data, right-justified |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Load data, right-justified, valid with ready |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Load refused; high in the done cycle |

## Verification
Two events can fall in the same cycle. The refusal flag and the done pulse coincide. A second start can also arrive while a transfer is still waiting on a stalled memory beat. Random loads with the check enabled and random protected indices make the refusal happen often, and the bench's own range model decides whether the flag is due in the done cycle. In those cases no beat and no register write may be seen. The bench also drives a second start during a back-pressured transfer. It then judges the result by comparing the whole register file and memory image with the model, so any effect of the ignored start would show up.

// File: rtl/string_xfer_seq.sv
module string_xfer_seq #(
  parameter int AW = 32,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic [CW-1:0] st_count,
  input  logic [4:0]    st_reg,
  input  logic          st_store,
  input  logic          st_check,
  input  logic [4:0]    st_base,
  input  logic [4:0]    st_index,
  output logic [4:0]    rf_rd_idx,
  input  logic [31:0]   rf_rd_data,
  output logic          rf_we,
  output logic [4:0]    rf_wr_idx,
  output logic [31:0]   rf_wr_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          illegal
);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_XFER, S_FIN} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic [4:0]    reg_q, base_q, idx_q;
  logic          store_q, chk_q, tail2_q, ill_q;
  logic [15:0]   hold_q;

  logic [CW:0]   nregs;
  logic [4:0]    dbase, didx;
  logic          in_base, in_idx, bad;
  logic          word_beat, beat, first_of_3;

  assign nregs   = ({1'b0, rem_q} + (CW+1)'(3)) >> 2;
  assign dbase   = base_q - reg_q;
  assign didx    = idx_q - reg_q;
  assign in_base = {{(CW-4){1'b0}}, dbase} < nregs;
  assign in_idx  = {{(CW-4){1'b0}}, didx} < nregs;
  assign bad     = chk_q && !store_q && (rem_q != '0) &&
                   (((base_q != 5'd0) && in_base) || in_idx);

  assign word_beat  = !tail2_q && (rem_q >= CW'(4));
  assign first_of_3 = !tail2_q && (rem_q == CW'(3));

  assign mem_req  = (state == S_XFER);
  assign mem_we   = store_q;
  assign mem_addr = addr_q;
  assign mem_size = tail2_q ? SZ_BYTE :
                    word_beat ? SZ_WORD :
                    (rem_q == CW'(1)) ? SZ_BYTE : SZ_HALF;
  assign beat     = mem_req && mem_ready;

  always_comb begin
    unique case (mem_size)
      SZ_WORD: mem_wdata = rf_rd_data;
      SZ_HALF: mem_wdata = {16'h0, rf_rd_data[31:16]};
      default: mem_wdata = {24'h0, tail2_q ? rf_rd_data[15:8] : rf_rd_data[31:24]};
    endcase
  end

  always_comb begin
    if (word_beat)            rf_wr_data = mem_rdata;
    else if (tail2_q)         rf_wr_data = {hold_q, mem_rdata[7:0], 8'h0};
    else if (rem_q == CW'(2)) rf_wr_data = {mem_rdata[15:0], 16'h0};
    else                      rf_wr_data = {mem_rdata[7:0], 24'h0};
  end

  assign rf_rd_idx = reg_q;
  assign rf_wr_idx = reg_q;
  assign rf_we     = beat && !store_q && !first_of_3;
  assign done      = (state == S_FIN);
  assign illegal   = (state == S_FIN) && ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      reg_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      store_q <= 1'b0;
      chk_q   <= 1'b0;
      tail2_q <= 1'b0;
      ill_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          addr_q  <= st_addr;
          rem_q   <= st_count;
          reg_q   <= st_reg;
          base_q  <= st_base;
          idx_q   <= st_index;
          store_q <= st_store;
          chk_q   <= st_check;
          tail2_q <= 1'b0;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          ill_q <= bad;
          state <= (bad || rem_q == '0) ? S_FIN : S_XFER;
        end
        S_XFER: if (beat) begin
          if (tail2_q) begin
            state <= S_FIN;
          end else if (word_beat) begin
            addr_q <= addr_q + AW'(4);
            reg_q  <= reg_q + 5'd1;
            rem_q  <= rem_q - CW'(4);
            if (rem_q == CW'(4)) state <= S_FIN;
          end else if (first_of_3) begin
            addr_q  <= addr_q + AW'(2);
            hold_q  <= mem_rdata[15:0];
            tail2_q <= 1'b1;
          end else begin
            state <= S_FIN;
          end
        end
        default: begin
          tail2_q <= 1'b0;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen_q <= 1'b0;
    else if (state == S_IDLE && start) seen_q <= 1'b0;
    else if (mem_req)                  seen_q <= 1'b1;
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !seen_q && !rf_we && !mem_req); // R7
  AST_TAIL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req && mem_ready && mem_size == SZ_HALF) && mem_req |->
      mem_size == SZ_BYTE && mem_addr == $past(mem_addr) + AW'(2)); // R6
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req && mem_ready && mem_size == SZ_WORD) && mem_req |->
      mem_addr == $past(mem_addr) + AW'(4)); // R2
  AST_NO_RF_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_we); // R5

endmodule

// File: tb/string_xfer_seq_bench.sv
module string_xfer_seq_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, st_store = 1'b0, st_check = 1'b0;
  logic [31:0] st_addr = '0;
  logic [6:0]  st_count = '0;
  logic [4:0]  st_reg = '0, st_base = '0, st_index = '0;
  logic [4:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata;
  logic        rf_we, mem_req, mem_we, done, illegal;
  logic        mem_ready = 1'b0;
  logic [1:0]  mem_size;

  always #(PERIOD/2) clk = ~clk;

  string_xfer_seq u_string_xfer_seq (
    .clk, .rst_n, .start, .st_addr, .st_count, .st_reg, .st_store, .st_check,
    .st_base, .st_index, .rf_rd_idx, .rf_rd_data, .rf_we, .rf_wr_idx,
    .rf_wr_data, .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata,
    .mem_ready, .mem_rdata, .done, .illegal);

  logic [7:0]  mem [256];
  logic [31:0] rf  [32];
  logic [7:0]  exp_mem [256];
  logic [31:0] exp_rf  [32];
  logic [7:0]  a0;
  assign a0 = mem_addr[7:0];
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata = (mem_size == 2'd2) ? {mem[a0], mem[a0+8'd1], mem[a0+8'd2], mem[a0+8'd3]} :
                     (mem_size == 2'd1) ? {16'h0, mem[a0], mem[a0+8'd1]} : {24'h0, mem[a0]};

  int errors = 0, checks = 0;
  int beats = 0, rfw = 0, stall_err = 0;
  int ready_pct = 75;
  logic [31:0] beat_addr [8];
  logic [1:0]  beat_size [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    logic prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [1:0]  prev_size = '0;
    forever begin
      @(negedge clk);
      mem_ready = ($urandom % 100) < ready_pct;
      #1;
      if (mem_req) begin
        if (prev_stall && (mem_addr != prev_addr || mem_size != prev_size)) stall_err++;
        prev_stall = !mem_ready; prev_addr = mem_addr; prev_size = mem_size;
      end else prev_stall = 1'b0;
      if (mem_req && mem_ready) begin
        if (beats < 8) begin beat_addr[beats] = mem_addr; beat_size[beats] = mem_size; end
        beats++;
        if (mem_we) begin
          if (mem_size == 2'd2) begin
            mem[a0] = mem_wdata[31:24]; mem[a0+8'd1] = mem_wdata[23:16];
            mem[a0+8'd2] = mem_wdata[15:8]; mem[a0+8'd3] = mem_wdata[7:0];
          end else if (mem_size == 2'd1) begin
            mem[a0] = mem_wdata[15:8]; mem[a0+8'd1] = mem_wdata[7:0];
          end else mem[a0] = mem_wdata[7:0];
        end
      end
      if (rf_we) begin rf[rf_wr_idx] = rf_wr_data; rfw++; end
    end
  end

  function automatic bit ref_illegal(input int cnt, input int r, input bit store,
                                     input bit chk, input int base, input int idx);
    int n = (cnt + 3) / 4;
    bit hit = 0;
    if (store || !chk || cnt == 0) return 0;
    for (int k = 0; k < n; k++) begin
      int x = (r + k) % 32;
      if ((x == base && base != 0) || x == idx) hit = 1;
    end
    return hit;
  endfunction

  task automatic build_expect(input logic [31:0] addr, input int cnt, input int r,
                              input bit store, input bit ill);
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
    if (ill) return;
    for (int i = 0; i < cnt; i++) begin
      int ri = (r + i / 4) % 32;
      int ln = 3 - (i % 4);
      logic [7:0] ma = addr[7:0] + 8'(i);
      if (store) exp_mem[ma] = rf[ri][ln*8 +: 8];
      else begin
        if (i % 4 == 0) exp_rf[ri] = '0;
        exp_rf[ri][ln*8 +: 8] = mem[ma];
      end
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] addr, input int cnt,
                        input int r, input bit store, input bit chk,
                        input int base, input int idx, input bit poke);
    bit ill = ref_illegal(cnt, r, store, chk, base, idx);
    int exp_beats = ill ? 0 : cnt / 4 + ((cnt % 4 == 3) ? 2 : (cnt % 4 != 0) ? 1 : 0);
    int exp_rfw = (ill || store) ? 0 : (cnt + 3) / 4;
    int bad_mem = 0, bad_rf = 0, waited = 0;
    build_expect(addr, cnt, r, store, ill);
    beats = 0; rfw = 0;
    @(negedge clk);
    st_addr = addr; st_count = 7'(cnt); st_reg = 5'(r); st_store = store;
    st_check = chk; st_base = 5'(base); st_index = 5'(idx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      st_addr = addr + 32'd64; st_count = 7'd9; st_reg = 5'(r + 7);
      st_store = !store; st_check = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    forever begin
      #2;
      if (done) break;
      waited++;
      if (waited > 2000) begin check(0, req, "timeout", 0, 1); return; end
      @(negedge clk);
    end
    check(illegal == ill, ill ? "R7" : req, "illegal flag", 32'(illegal), 32'(ill));
    @(negedge clk); #2;
    check(!done, "R9", "done width", 32'(done), 0);
    check(beats == exp_beats, req, "beat count", beats, exp_beats);
    check(rfw == exp_rfw, req, "rf writes", rfw, exp_rfw);
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad_mem++;
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) bad_rf++;
    check(bad_mem == 0, req, "memory mismatches", bad_mem, 0);
    check(bad_rf == 0, req, "register mismatches", bad_rf, 0);
  endtask

  task automatic finish_up();
    check(stall_err == 0, "R10", "request changed while stalled", stall_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", "run did not end", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    repeat (3) @(negedge clk);
    #2;
    check(!done && !mem_req && !rf_we && !illegal, "R9", "reset outputs",
          {done, mem_req, rf_we, illegal}, 0);
    rst_n = 1'b1;

    run_op("R1", 32'h40, 0, 5, 0, 1, 5, 5, 0);
    run_op("R1", 32'h40, 0, 9, 1, 0, 0, 0, 0);
    run_op("R2", 32'h10, 12, 3, 0, 0, 0, 0, 0);
    run_op("R2", 32'h80, 8, 20, 1, 0, 0, 0, 0);
    run_op("R3", 32'h20, 16, 30, 0, 0, 0, 0, 0);
    run_op("R3", 32'hA0, 12, 31, 1, 0, 0, 0, 0);
    run_op("R4", 32'h31, 5, 4, 0, 0, 0, 0, 0);
    run_op("R4", 32'h37, 6, 8, 0, 0, 0, 0, 0);
    run_op("R4", 32'h51, 2, 11, 0, 0, 0, 0, 0);
    run_op("R5", 32'hC1, 5, 12, 1, 0, 0, 0, 0);
    run_op("R5", 32'hC9, 6, 13, 1, 0, 0, 0, 0);
    run_op("R5", 32'hD3, 3, 14, 1, 0, 0, 0, 0);
    run_op("R6", 32'h61, 7, 2, 0, 0, 0, 0, 0);
    check(beat_addr[1] == 32'h65 && beat_size[1] == 2'd1, "R6", "half beat",
          {beat_addr[1][29:0], beat_size[1]}, {30'h65, 2'd1});
    check(beat_addr[2] == 32'h67 && beat_size[2] == 2'd0, "R6", "byte beat",
          {beat_addr[2][29:0], beat_size[2]}, {30'h67, 2'd0});
    run_op("R6", 32'h71, 7, 16, 1, 0, 0, 0, 0);
    run_op("R7", 32'h00, 9, 30, 0, 1, 0, 0, 0);
    run_op("R7", 32'h00, 9, 30, 0, 1, 0, 31, 0);
    run_op("R7", 32'h00, 9, 30, 0, 1, 5, 9, 0);
    run_op("R7", 32'h00, 8, 30, 0, 1, 0, 0, 0);
    run_op("R7", 32'h00, 8, 30, 0, 1, 31, 4, 0);
    run_op("R7", 32'h00, 127, 6, 0, 1, 0, 6, 0);
    run_op("R8", 32'hFFFF_FFFC, 8, 1, 0, 0, 0, 0, 0);
    check(beat_addr[1] == 32'h0, "R8", "wrapped address", beat_addr[1], 0);
    run_op("R2", 32'h00, 127, 6, 0, 0, 0, 0, 0);
    ready_pct = 30;
    run_op("R9", 32'h90, 20, 18, 0, 0, 0, 0, 1);
    run_op("R9", 32'h18, 14, 22, 1, 0, 0, 0, 1);
    for (int n = 0; n < 150; n++) begin
      ready_pct = 40 + ($urandom % 61);
      run_op("R2", $urandom, $urandom % 41, $urandom % 32, $urandom % 2,
             $urandom % 2, $urandom % 32, $urandom % 32, 0);
    end
    finish_up();
  end
endmodule